// File: doc/BRIEF.md
# Configurable PCI Base Address Register

This block is one PCI base address register whose type and window size come from a single 32-bit configuration word. The word is sampled on every clock cycle while reset is held low. Bit 0 of the word selects the style. A 1 gives an I/O register, with two fixed low bits. A 0 gives a memory register, with four fixed low bits. Those low bits of the word become the read-only type bits that the register reports. The remaining upper bits of the word act as a mask of the address bits that software may set, and the mask also sets the size of the window.

Configuration software writes dwords through a write strobe with per-byte enables. The current register value is always visible on the read port. Writing all ones and reading back gives the writable mask merged with the fixed type bits, so the window size can be derived from the result. Because the type bits are taken from the configuration word rather than hardwired, an I/O register can report the normally reserved bit 1 as set.

Top module: `pci_bar_reg`

## Requirements
- R1: Configuration bit 0 selects the style. A 1 means I/O, with fixed low field bits [1:0] and bits [3:2] writable when masked. A 0 means memory, with fixed low field bits [3:0].
- R2: The fixed low field always reads equal to the same bits of the configuration word, including I/O bit 1 reading as 1 when the word sets it.
- R3: A write with all four byte enables set loads every writable bit from the write data. The writable bits are the configuration bits that are 1 above the fixed field.
- R4: A bit above the fixed field whose configuration bit is 0 always reads 0, whatever is written.
- R5: A full all-ones write followed by a read returns the writable mask ORed with the fixed low field.
- R6: Byte enable bit i governs data bits [8i+7:8i]. A lane whose enable is 0 keeps its prior contents.
- R7: While reset is low, the configuration word is sampled. After reset, the register reads the fixed low field with every writable bit cleared.
- R8: When the write strobe is low, the register value does not change, whatever the data and enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the configuration word is sampled while it is low |
| cfg_word | input | 32 | Configuration word: style in bit 0, type defaults in the low field, writable mask above it |
| wr_en | input | 1 | Config write strobe |
| wr_be | input | 4 | Byte enables, one per 8-bit lane |
| wr_data | input | 32 | Config write data |
| bar_q | output | 32 | Current register value, returned on config reads |

## Verification
Four configuration words are applied, each through its own reset:
- an I/O word with reserved bit 1 set;
- an I/O word with a narrow window;
- a small prefetchable memory window;
- a large memory window.

For each word, the bench first reads the reset value. It then does an all-ones sizing write, which exposes the mask. A zero write follows, which separates I/O from memory through bits [3:2].

Next, all sixteen byte-enable combinations are tried with three data patterns. These are alternating bits, a per-lane distinct value and all zeros. The patterns make a lane that leaked or stuck show up as a changed byte. A final write with the strobe low shows that the register ignores data when no write is active.

// File: rtl/pci_bar_pkg.sv
package pci_bar_pkg;

  localparam int unsigned BAR_W        = 32;
  localparam int unsigned BAR_LANE_W   = 8;
  localparam int unsigned IO_LOW_BITS  = 2;
  localparam int unsigned MEM_LOW_BITS = 4;

  typedef enum logic { SPACE_MEM = 1'b0, SPACE_IO = 1'b1 } bar_space_e;

  function automatic bar_space_e space_of(input logic [BAR_W-1:0] cfg);
    return cfg[0] ? SPACE_IO : SPACE_MEM;
  endfunction

  // Read-only type field: two bits for I/O, four for memory.
  function automatic logic [BAR_W-1:0] fixed_field(input bar_space_e sp);
    logic [BAR_W-1:0] m;
    m = '0;
    for (int b = 0; b < int'(MEM_LOW_BITS); b++) begin
      if (sp == SPACE_MEM || b < int'(IO_LOW_BITS)) m[b] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [BAR_W-1:0] writable_bits(input logic [BAR_W-1:0] cfg);
    return cfg & ~fixed_field(space_of(cfg));
  endfunction

  function automatic logic [BAR_W-1:0] reset_image(input logic [BAR_W-1:0] cfg);
    return cfg & fixed_field(space_of(cfg));
  endfunction

  // Per-lane update: masked bits take new data, others hold.
  function automatic logic [BAR_LANE_W-1:0] lane_merge(
    input logic [BAR_LANE_W-1:0] old_v,
    input logic [BAR_LANE_W-1:0] new_v,
    input logic [BAR_LANE_W-1:0] wm
  );
    return (old_v & ~wm) | (new_v & wm);
  endfunction

endpackage

// File: rtl/pci_bar_cfg.sv
module pci_bar_cfg
  import pci_bar_pkg::*;
#(
  parameter int unsigned DATA_W = BAR_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_in,
  output logic [DATA_W-1:0] cfg_q,
  output logic              is_io,
  output logic [DATA_W-1:0] fixed_mask,
  output logic [DATA_W-1:0] wr_mask,
  output logic [DATA_W-1:0] rst_value
);

  always_ff @(posedge clk) begin
    if (!rst_n) cfg_q <= cfg_in;
  end

  always_comb begin
    is_io      = (space_of(cfg_q) == SPACE_IO);
    fixed_mask = fixed_field(space_of(cfg_q));
    wr_mask    = writable_bits(cfg_q);
    rst_value  = reset_image(cfg_in);
  end

endmodule

// File: rtl/pci_bar_lane.sv
module pci_bar_lane
  import pci_bar_pkg::*;
#(
  parameter int unsigned LANE_W = BAR_LANE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] rst_val,
  input  logic [LANE_W-1:0] wmask,
  input  logic              lane_wr,
  input  logic [LANE_W-1:0] wdata,
  output logic [LANE_W-1:0] q
);

  logic [LANE_W-1:0] next_q;

  always_comb begin
    next_q = lane_wr ? lane_merge(q, wdata, wmask) : q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= rst_val;
    else        q <= next_q;
  end

endmodule

// File: rtl/pci_bar_reg.sv
module pci_bar_reg
  import pci_bar_pkg::*;
#(
  parameter int unsigned DATA_W = BAR_W,
  parameter int unsigned LANE_W = BAR_LANE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [DATA_W-1:0]        cfg_word,
  input  logic                     wr_en,
  input  logic [DATA_W/LANE_W-1:0] wr_be,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [DATA_W-1:0]        bar_q
);

  localparam int unsigned LANES = DATA_W / LANE_W;

  logic [DATA_W-1:0] cfg_q;
  logic              is_io;
  logic [DATA_W-1:0] fixed_mask;
  logic [DATA_W-1:0] wr_mask;
  logic [DATA_W-1:0] rst_value;
  logic [LANES-1:0]  lane_wr;

  pci_bar_cfg #(.DATA_W(DATA_W)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_in     (cfg_word),
    .cfg_q      (cfg_q),
    .is_io      (is_io),
    .fixed_mask (fixed_mask),
    .wr_mask    (wr_mask),
    .rst_value  (rst_value)
  );

  assign lane_wr = wr_be & {LANES{wr_en}};

  for (genvar i = 0; i < int'(LANES); i++) begin : g_lane
    pci_bar_lane #(.LANE_W(LANE_W)) u_lane (
      .clk     (clk),
      .rst_n   (rst_n),
      .rst_val (rst_value[i*LANE_W +: LANE_W]),
      .wmask   (wr_mask[i*LANE_W +: LANE_W]),
      .lane_wr (lane_wr[i]),
      .wdata   (wr_data[i*LANE_W +: LANE_W]),
      .q       (bar_q[i*LANE_W +: LANE_W])
    );
  end

endmodule

// File: rtl/pci_bar_reg_chk.sv
module pci_bar_reg_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned LANES  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [LANES-1:0]  wr_be,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] bar_q,
  input logic [DATA_W-1:0] cfg_q,
  input logic [DATA_W-1:0] wr_mask,
  input logic [DATA_W-1:0] fixed_mask,
  input logic              is_io
);

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R1
  p_style_field_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fixed_mask[3:0] == (is_io ? 4'h3 : 4'hF)));

  p_fixed_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((bar_q & fixed_mask) == (cfg_q & fixed_mask)));

  p_full_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_en && (&wr_be)) |=> ((bar_q & wr_mask) == ($past(wr_data) & wr_mask)));

  p_unmasked_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((bar_q & ~(wr_mask | fixed_mask)) == '0));

  p_lane0_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_en && !wr_be[0]) |=> $stable(bar_q[7:0]));

  p_lane3_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && wr_en && !wr_be[LANES-1]) |=> $stable(bar_q[DATA_W-1 -: 8]));

  p_reset_image_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !past_ok |-> (bar_q == (cfg_q & fixed_mask)));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !wr_en) |=> $stable(bar_q));

endmodule

bind pci_bar_reg pci_bar_reg_chk #(.DATA_W(DATA_W), .LANES(DATA_W/LANE_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_be      (wr_be),
  .wr_data    (wr_data),
  .bar_q      (bar_q),
  .cfg_q      (cfg_q),
  .wr_mask    (wr_mask),
  .fixed_mask (fixed_mask),
  .is_io      (is_io)
);

// File: tb/pci_bar_reg_tb.sv
module pci_bar_reg_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_word = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_be = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] bar_q;

  int n_cmp = 0;
  int n_bad = 0;
  logic done = 1'b0;

  always #5 clk = ~clk;

  pci_bar_reg u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_word (cfg_word),
    .wr_en    (wr_en),
    .wr_be    (wr_be),
    .wr_data  (wr_data),
    .bar_q    (bar_q)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic en, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    wr_en = en; wr_be = be; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_be = '0; wr_data = '0;
  endtask

  function automatic logic [31:0] be_bits(input logic [3:0] be);
    logic [31:0] m;
    m = '0;
    for (int k = 0; k < 4; k++) if (be[k]) m = m | (32'hFF << (8 * k));
    return m;
  endfunction

  initial begin
    logic [31:0] cfgs [4];
    logic [31:0] pats [3];
    logic [31:0] c, fm, wm, model, m;
    logic io;
    cfgs[0] = 32'hFFFF_FF03; // I/O, reserved bit 1 set, 256 B
    cfgs[1] = 32'hFFFF_FFF1; // I/O, 16 B
    cfgs[2] = 32'hFFFF_F008; // memory, prefetchable, 4 KB
    cfgs[3] = 32'hFFF0_0000; // memory, 1 MB
    pats[0] = 32'hA5A5_5A5A;
    pats[1] = 32'h1357_9BDF;
    pats[2] = 32'h0000_0000;
    for (int ci = 0; ci < 4; ci++) begin
      c  = cfgs[ci];
      io = c[0];
      fm = io ? 32'h3 : 32'hF;
      wm = c & ~fm;
      @(negedge clk);
      rst_n = 1'b0; cfg_word = c;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      cfg_word = 32'h0;          // must be ignored outside reset
      @(negedge clk);
      check("R7 reset value", bar_q, c & fm);
      check("R2 fixed field", bar_q & fm, c & fm);
      do_write(1'b1, 4'hF, 32'hFFFF_FFFF);
      check("R5 sizing readback", bar_q, wm | (c & fm));
      check("R4 unmasked bits zero", bar_q & ~(wm | fm), 32'h0);
      do_write(1'b1, 4'hF, 32'h0);
      check("R1 style low field", {28'h0, bar_q[3:0]}, {28'h0, io ? {2'b00, c[1:0]} : c[3:0]});
      model = c & fm;
      for (int pi = 0; pi < 3; pi++) begin
        for (int b = 0; b < 16; b++) begin
          do_write(1'b1, 4'(b), pats[pi] ^ (32'h0101_0101 * 32'(b)));
          m = be_bits(4'(b)) & wm;
          model = (model & ~m) | ((pats[pi] ^ (32'h0101_0101 * 32'(b))) & m);
          if (b == 15) check("R3 full write", bar_q, model);
          else         check("R6 byte enables", bar_q, model);
        end
      end
      do_write(1'b0, 4'hF, ~model);
      check("R8 idle strobe", bar_q, model);
      do_write(1'b1, 4'h0, ~model);
      check("R6 no lanes enabled", bar_q, model);
    end
    done = 1'b1;
  end

  initial begin
    for (int t = 0; t < 200000; t++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule